// File: doc/BRIEF.md
# DRAM Row-Activate Timing Guard

This block sits beside a DRAM command scheduler and answers one question every clock cycle: may a row-activate go out right now to the rank and bank that the scheduler names? It keeps, for each rank, the state needed for three spacing rules. Two activates to the same rank must be a minimum number of cycles apart. A bank that was just opened may not be opened again until its row cycle has finished. A rolling window caps how many activates one rank may issue.

The scheduler presents a request with a rank index and a bank index and reads back a grant in the same cycle. When it actually sends the activate, it raises a commit strobe alongside the same request. Only a commit that is granted updates the timers. All timing values are programmable cycle counts, already converted from nanoseconds and rounded up by the caller. The row cycle is the active time plus the precharge time. In close-page mode it is the larger of that sum and RCD + CAS latency + precharge. Setting the window length to zero turns the window rule off.

Top module: `act_guard`

## Requirements
- R1: After a granted commit to rank r on clock edge t, no bank of rank r is granted for a commit before edge t + cfg_trrd.
- R2: In open-page mode (cfg_close_page = 0), the bank that was committed on edge t is not granted again before edge t + cfg_tras + cfg_trp.
- R3: With cfg_txaw > 0, a rank that committed ACT_LIMIT activates, the oldest on edge t, is not granted again before edge t + cfg_txaw. Once every rule is met, the grant returns.
- R4: With cfg_txaw = 0, the window rule is disabled, and only the rank spacing and row-cycle rules gate the grant.
- R5: In close-page mode (cfg_close_page = 1), the row-cycle wait of the committed bank is max(cfg_tras + cfg_trp, cfg_trcd + cfg_tcl + cfg_trp).
- R6: Ranks are independent: commits to one rank never delay a grant to another rank.
- R7: A commit strobe raised while act_grant is low has no effect on any timer.
- R8: After reset, every rank and bank is granted as soon as it is requested.
- R9: act_grant is combinational from the current timers and the request inputs, and it is low whenever req_valid is low.
- R10: A commit never shortens a wait that is already pending. A rank-spacing load to a bank that is still in its row cycle leaves the longer wait in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trrd | input | CNT_W | Rank activate-to-activate spacing, in cycles |
| cfg_tras | input | CNT_W | Row active time, in cycles |
| cfg_trp | input | CNT_W | Precharge time, in cycles |
| cfg_trcd | input | CNT_W | Activate-to-column delay, in cycles |
| cfg_tcl | input | CNT_W | Column access latency, in cycles |
| cfg_close_page | input | 1 | 1 selects the close-page row-cycle bound |
| cfg_txaw | input | WIN_W | Rolling window length in cycles; 0 disables the window |
| req_valid | input | 1 | Activate request present |
| req_rank | input | RANK_W | Requested rank |
| req_bank | input | BANK_W | Requested bank |
| act_commit | input | 1 | The requested activate is issued this cycle |
| act_grant | output | 1 | The request may be issued this cycle |

## Verification
The bench probes each wait at its exact last blocked cycle and its first open cycle. A design that counts one cycle off therefore fails at one edge or the other. The window is tested with the spacing rule already satisfied, so a guard that ignores the oldest history entry would grant a fifth activate early. A commit with no grant is followed by a probe that a wrongly restarted timer would block. A short rank-spacing load is placed over a long row-cycle wait, so a timer that overwrites instead of taking the maximum reopens the bank too soon. The close-page bound and the disabled window are each checked against values that the default path would get wrong.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

  typedef enum logic {
    PAGE_OPEN  = 1'b0,
    PAGE_CLOSE = 1'b1
  } page_mode_e;

endpackage

// File: rtl/act_rc_bound.sv
module act_rc_bound
  import act_guard_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = CNT_W + 2
) (
  input  logic [CNT_W-1:0] tras,
  input  logic [CNT_W-1:0] trp,
  input  logic [CNT_W-1:0] trcd,
  input  logic [CNT_W-1:0] tcl,
  input  page_mode_e       mode,
  output logic [TMR_W-1:0] rc_cycles
);

  logic [TMR_W-1:0] open_sum;
  logic [TMR_W-1:0] close_sum;

  always_comb begin
    open_sum  = TMR_W'(tras) + TMR_W'(trp);
    close_sum = TMR_W'(trcd) + TMR_W'(tcl) + TMR_W'(trp);
    rc_cycles = open_sum;
    if (mode == PAGE_CLOSE && close_sum > open_sum) begin
      rc_cycles = close_sum;
    end
  end

endmodule

// File: rtl/act_bank_timer.sv
module act_bank_timer #(
  parameter int TMR_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_rank,
  input  logic             hit_bank,
  input  logic [TMR_W-1:0] trrd,
  input  logic [TMR_W-1:0] trc,
  output logic             ready
);

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] dec;
  logic [TMR_W-1:0] want;
  logic [TMR_W-1:0] want_m1;
  logic [TMR_W-1:0] nxt;

  // Cycles remaining until the next activate is allowed; zero means open.
  always_comb begin
    dec  = (cnt != '0) ? cnt - 1'b1 : '0;
    want = trrd;
    if (hit_bank && trc > want) begin
      want = trc;
    end
    want_m1 = (want != '0) ? want - 1'b1 : '0;
    nxt = dec;
    if (hit_rank && want_m1 > dec) begin
      nxt = want_m1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      cnt <= nxt;
    end
  end

  assign ready = (cnt == '0);

  AST_RRD_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (hit_rank && trrd >= TMR_W'(2)) |=> !ready) else $error("rank spacing not held"); // R1

  AST_RC_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (hit_bank && trc >= TMR_W'(2)) |=> !ready) else $error("row cycle not held"); // R2

  AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ready && !hit_rank) |=> ready) else $error("idle bank became blocked"); // R7

endmodule

// File: rtl/act_xaw_window.sv
module act_xaw_window #(
  parameter int ACT_LIMIT = 4,
  parameter int WIN_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [WIN_W-1:0] txaw,
  output logic             ok
);

  localparam int PTR_W = (ACT_LIMIT > 1) ? $clog2(ACT_LIMIT) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ACT_LIMIT - 1);

  // Saturating age of each of the last ACT_LIMIT activates; ptr marks the oldest.
  logic [WIN_W-1:0] age [ACT_LIMIT];
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      for (int i = 0; i < ACT_LIMIT; i++) begin
        age[i] <= '1;
      end
    end else begin
      for (int i = 0; i < ACT_LIMIT; i++) begin
        if (commit && ptr == PTR_W'(i)) begin
          age[i] <= WIN_W'(1);
        end else if (age[i] != '1) begin
          age[i] <= age[i] + 1'b1;
        end
      end
      if (commit) begin
        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
    end
  end

  assign ok = (txaw == '0) || (age[ptr] >= txaw);

  for (genvar g = 0; g < ACT_LIMIT; g++) begin : g_age_chk
    AST_AGE_MONO: assert property (@(posedge clk) disable iff (rst)
      !(commit && ptr == PTR_W'(g)) |=> age[g] >= $past(age[g])) else $error("history age went back"); // R3
  end

endmodule

// File: rtl/act_guard.sv
module act_guard
  import act_guard_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int ACT_LIMIT = 4,
  parameter int CNT_W     = 8,
  parameter int WIN_W     = 8,
  parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_trrd,
  input  logic [CNT_W-1:0]  cfg_tras,
  input  logic [CNT_W-1:0]  cfg_trp,
  input  logic [CNT_W-1:0]  cfg_trcd,
  input  logic [CNT_W-1:0]  cfg_tcl,
  input  logic              cfg_close_page,
  input  logic [WIN_W-1:0]  cfg_txaw,
  input  logic              req_valid,
  input  logic [RANK_W-1:0] req_rank,
  input  logic [BANK_W-1:0] req_bank,
  input  logic              act_commit,
  output logic              act_grant
);

  localparam int TMR_W = CNT_W + 2;

  logic [TMR_W-1:0] rc_cycles;
  logic [TMR_W-1:0] trrd_ext;
  logic             commit_eff;
  logic             bank_rdy [NUM_RANKS][NUM_BANKS];
  logic             win_ok   [NUM_RANKS];

  assign trrd_ext = TMR_W'(cfg_trrd);

  act_rc_bound #(
    .CNT_W (CNT_W),
    .TMR_W (TMR_W)
  ) u_rc_bound (
    .tras      (cfg_tras),
    .trp       (cfg_trp),
    .trcd      (cfg_trcd),
    .tcl       (cfg_tcl),
    .mode      (page_mode_e'(cfg_close_page)),
    .rc_cycles (rc_cycles)
  );

  assign act_grant  = req_valid && bank_rdy[req_rank][req_bank] && win_ok[req_rank];
  assign commit_eff = act_commit && act_grant;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic hit_rank;
    assign hit_rank = commit_eff && (req_rank == RANK_W'(r));

    act_xaw_window #(
      .ACT_LIMIT (ACT_LIMIT),
      .WIN_W     (WIN_W)
    ) u_window (
      .clk    (clk),
      .rst    (rst),
      .commit (hit_rank),
      .txaw   (cfg_txaw),
      .ok     (win_ok[r])
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit_bank;
      assign hit_bank = hit_rank && (req_bank == BANK_W'(b));

      act_bank_timer #(
        .TMR_W (TMR_W)
      ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .hit_rank (hit_rank),
        .hit_bank (hit_bank),
        .trrd     (trrd_ext),
        .trc      (rc_cycles),
        .ready    (bank_rdy[r][b])
      );
    end
  end

  AST_RANK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (commit_eff && cfg_trrd >= CNT_W'(2)) ##1 (req_rank == $past(req_rank)) |-> !act_grant)
    else $error("same-rank grant inside spacing"); // R1

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> !act_grant) else $error("grant without request"); // R9

endmodule

// File: tb/act_guard_bench.sv
module act_guard_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_trrd, cfg_tras, cfg_trp, cfg_trcd, cfg_tcl, cfg_txaw;
  logic       cfg_close_page;
  logic       req_valid = 1'b0;
  logic [0:0] req_rank = '0;
  logic [2:0] req_bank = '0;
  logic       act_commit = 1'b0;
  logic       act_grant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  act_guard u_act_guard (
    .clk            (clk),
    .rst            (rst),
    .cfg_trrd       (cfg_trrd),
    .cfg_tras       (cfg_tras),
    .cfg_trp        (cfg_trp),
    .cfg_trcd       (cfg_trcd),
    .cfg_tcl        (cfg_tcl),
    .cfg_close_page (cfg_close_page),
    .cfg_txaw       (cfg_txaw),
    .req_valid      (req_valid),
    .req_rank       (req_rank),
    .req_bank       (req_bank),
    .act_commit     (act_commit),
    .act_grant      (act_grant)
  );

  // {req tag[3:0], valid, rank, bank[2:0], commit, expected grant}
  // Config: trrd=2, tras=4, trp=2 (row cycle 6), window 10, limit 4.
  localparam logic [10:0] VEC [15] = '{
    {4'd1,  1'b1, 1'b0, 3'd0, 1'b1, 1'b1}, // R1 first activate, edge 0
    {4'd7,  1'b1, 1'b0, 3'd1, 1'b1, 1'b0}, // R7 blocked commit must be ignored
    {4'd1,  1'b1, 1'b0, 3'd1, 1'b1, 1'b1}, // R1 spacing met at edge 2
    {4'd6,  1'b1, 1'b1, 3'd0, 1'b1, 1'b1}, // R6 other rank free
    {4'd1,  1'b1, 1'b0, 3'd2, 1'b1, 1'b1}, // R1 edge 4
    {4'd2,  1'b1, 1'b0, 3'd0, 1'b1, 1'b0}, // R2 bank 0 still in row cycle
    {4'd1,  1'b1, 1'b0, 3'd3, 1'b1, 1'b1}, // R1 edge 6, fourth activate
    {4'd1,  1'b1, 1'b0, 3'd0, 1'b0, 1'b0}, // R1 spacing after edge 6
    {4'd3,  1'b1, 1'b0, 3'd0, 1'b1, 1'b0}, // R3 window blocks, oldest edge 0
    {4'd6,  1'b1, 1'b1, 3'd1, 1'b1, 1'b1}, // R6 rank 1 unaffected by window
    {4'd3,  1'b1, 1'b0, 3'd0, 1'b1, 1'b1}, // R3 window reopens at edge 10
    {4'd3,  1'b1, 1'b0, 3'd4, 1'b1, 1'b0}, // R3 oldest now edge 2
    {4'd3,  1'b1, 1'b0, 3'd4, 1'b1, 1'b1}, // R3 edge 12
    {4'd9,  1'b0, 1'b0, 3'd5, 1'b1, 1'b0}, // R9 no request, no grant
    {4'd9,  1'b1, 1'b0, 3'd5, 1'b1, 1'b1}  // R9 request returns, edge 14
  };

  task automatic step(input logic v, input logic [0:0] r, input logic [2:0] b,
                      input logic c, input logic e, input string tag);
    @(negedge clk);
    req_valid  = v;
    req_rank   = r;
    req_bank   = b;
    act_commit = c;
    #1;
    checks++;
    if (act_grant !== e) begin
      fails++;
      $display("FAIL %s: grant=%0b expected %0b (rank %0d bank %0d)", tag, act_grant, e, r, b);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    act_commit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_cfg(input int trrd, input int tras, input int trp, input int trcd,
                         input int tcl, input logic close_pg, input int txaw);
    cfg_trrd = 8'(trrd);
    cfg_tras = 8'(tras);
    cfg_trp = 8'(trp);
    cfg_trcd = 8'(trcd);
    cfg_tcl = 8'(tcl);
    cfg_close_page = close_pg;
    cfg_txaw = 8'(txaw);
  endtask

  initial begin
    set_cfg(2, 4, 2, 2, 2, 1'b0, 10);
    do_reset();

    // R8: every rank and bank open straight after reset
    for (int r = 0; r < 2; r++) begin
      for (int b = 0; b < 8; b++) begin
        step(1'b1, 1'(r), 3'(b), 1'b0, 1'b1, "R8 reset grant");
      end
    end
    // R9: no request, no grant
    step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R9 idle");

    // Vector walk (R1, R2, R3, R6, R7, R9)
    do_reset();
    for (int i = 0; i < 15; i++) begin
      logic [10:0] vv;
      vv = VEC[i];
      step(vv[6], vv[5], vv[4:2], vv[1], vv[0], $sformatf("R%0d vector %0d", vv[10:7], i));
    end

    // R4: window disabled, six back-to-back activates in one rank
    set_cfg(1, 4, 2, 2, 2, 1'b0, 0);
    do_reset();
    for (int b = 0; b < 6; b++) begin
      step(1'b1, 1'b0, 3'(b), 1'b1, 1'b1, "R4 window off");
    end

    // R5: close-page bound 3+4+2=9 beats open bound 1+2=3
    set_cfg(1, 1, 2, 3, 4, 1'b1, 0);
    do_reset();
    step(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, "R5 commit");
    for (int k = 1; k <= 8; k++) begin
      step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "R5 close-page wait");
    end
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, "R5 close-page reopen");

    // R10: short rank-spacing load must not cut a pending row cycle of 6
    set_cfg(1, 4, 2, 2, 2, 1'b0, 0);
    do_reset();
    step(1'b1, 1'b0, 3'd0, 1'b1, 1'b1, "R10 commit bank 0");
    step(1'b1, 1'b0, 3'd1, 1'b1, 1'b1, "R10 commit bank 1");
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "R10 bank 0 still busy");
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "R10 bank 0 still busy");
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "R10 bank 0 still busy");
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "R10 bank 0 last busy cycle");
    step(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, "R10 bank 0 reopens");
    // R2: open-page row cycle alone, spacing 1
    step(1'b1, 1'b1, 3'd2, 1'b1, 1'b1, "R2 commit rank 1");
    for (int k = 1; k <= 5; k++) begin
      step(1'b1, 1'b1, 3'd2, 1'b0, 1'b0, "R2 row cycle wait");
    end
    step(1'b1, 1'b1, 3'd2, 1'b0, 1'b1, "R2 row cycle done");

    step(1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "R9 final idle");
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule